// File: doc/BRIEF.md
# Burst Line Write Buffer and Read Line Cache

This block sits between a 16-bit processor bus and a memory controller that only ever moves aligned bursts of four consecutive words. Processor writes are posted: they are taken into a one-line buffer and acknowledged at once. The processor then continues while the write waits for the memory. Further writes that fall inside the same burst line are folded into that buffer at byte granularity. The buffer keeps a per-byte enable mask, and the whole line goes to memory as one masked burst.

On the read side, the last burst fetched from memory is kept as a single cached line. A read to any word of that line is answered without a memory access. Writes that hit the cached line patch the affected bytes of the cached copy in the same cycle, so a later read never sees stale data. A read miss while a write is pending first drains the buffer and then fetches the new line. A write to a different line while the buffer is occupied is held back until the pending burst has been acknowledged.

Top module: `burst_cache_bridge`

## Requirements
- R1: After reset `cpu_ack` and `mem_req` are low, and both the read line and the write buffer are empty, so the first read of any address causes a memory read burst.
- R2: A write accepted while the buffer is empty or holds the same line is acknowledged one cycle after acceptance, without any memory request.
- R3: Writes to words of the line already held in the write buffer merge into it and start no memory transfer of their own.
- R4: A write burst carries word w on `mem_wdata[16w+15:16w]` and its byte enables on `mem_be[2w+1]` (upper byte) and `mem_be[2w]` (lower byte); a byte is enabled only if some merged write strobed it, and bytes not enabled stay unchanged in memory.
- R5: A write to a different line while a write is pending gets no acknowledge until the pending burst has been issued and acknowledged by the memory.
- R6: A read that misses while a write is pending issues the write burst first, and only after that the read burst; a read burst is never requested while a write is pending.
- R7: A read to any word of the cached line is acknowledged one cycle after acceptance with no memory request.
- R8: A write to the cached line updates the strobed bytes of the cached copy, so the next read hit returns the merged data.
- R9: Once raised, `mem_req`, `mem_we` and `mem_addr` hold steady until `mem_ack`.
- R10: `mem_addr` is the line index, i.e. the word address with its two low bits dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, held until acknowledged |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_be | input | DATA_W/8 | Byte strobes, bit 1 upper byte, bit 0 lower byte |
| cpu_ack | output | 1 | One-cycle acknowledge |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_ack` |
| mem_req | output | 1 | Burst request to memory |
| mem_we | output | 1 | Burst direction, 1 = write |
| mem_addr | output | ADDR_W-2 | Line index |
| mem_wdata | output | 4*DATA_W | Write burst data |
| mem_be | output | 4*DATA_W/8 | Write burst byte mask |
| mem_ack | input | 1 | One-cycle burst completion |
| mem_rdata | input | 4*DATA_W | Read burst data, valid with `mem_ack` |

## Verification
On every cycle the assertions check that a memory request stays steady until acknowledged, that a write burst always carries a non-empty mask from a pending buffer, that no read burst starts while a write is pending, and that acknowledges are single pulses. Only the bench scenarios can show the data side: that merged bytes land in memory with the right mask and line index, that drain-then-fetch happens in that order, that stalled writes wait, and that reads after write hits return the patched bytes.

// File: rtl/burst_bridge_pkg.sv
package burst_bridge_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WDRAIN = 2'd1,
    ST_RFILL  = 2'd2
  } bridge_state_t;
endpackage

// File: rtl/burst_wbuf.sv
module burst_wbuf #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int BURST  = 4,
  localparam int OFF_W  = $clog2(BURST),
  localparam int LINE_W = ADDR_W - OFF_W,
  localparam int BE_W   = DATA_W / 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      load,
  input  logic                      merge,
  input  logic                      clear,
  input  logic [LINE_W-1:0]         line_in,
  input  logic [OFF_W-1:0]          sel,
  input  logic [DATA_W-1:0]         wdata,
  input  logic [BE_W-1:0]           be,
  output logic                      pend,
  output logic [LINE_W-1:0]         line,
  output logic [BURST*DATA_W-1:0]   data_flat,
  output logic [BURST*BE_W-1:0]     be_flat
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      line <= '0;
    end else if (load) begin
      pend <= 1'b1;
      line <= line_in;
    end else if (clear) begin
      pend <= 1'b0;
    end
  end

  for (genvar w = 0; w < BURST; w++) begin : g_word
    wire hit_w = (sel == OFF_W'(w));
    always_ff @(posedge clk) begin
      if (rst) be_flat[w*BE_W +: BE_W] <= '0;
      else if (load) be_flat[w*BE_W +: BE_W] <= hit_w ? be : '0;
      else if (merge && hit_w) be_flat[w*BE_W +: BE_W] <= be_flat[w*BE_W +: BE_W] | be;
    end
    for (genvar b = 0; b < BE_W; b++) begin : g_byte
      always_ff @(posedge clk) begin
        if ((load || merge) && hit_w && be[b])
          data_flat[w*DATA_W + b*8 +: 8] <= wdata[b*8 +: 8];
      end
    end
  end

  // R3: buffer cannot merge and load on the same cycle
  p_load_merge_excl_r3: assert property (@(posedge clk) disable iff (rst) !(load && merge));
endmodule

// File: rtl/burst_rline.sv
module burst_rline #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int BURST  = 4,
  localparam int OFF_W  = $clog2(BURST),
  localparam int LINE_W = ADDR_W - OFF_W,
  localparam int BE_W   = DATA_W / 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      fill,
  input  logic [LINE_W-1:0]         fill_line,
  input  logic [BURST*DATA_W-1:0]   fill_data,
  input  logic                      upd,
  input  logic [OFF_W-1:0]          sel,
  input  logic [DATA_W-1:0]         wdata,
  input  logic [BE_W-1:0]           be,
  output logic                      valid,
  output logic [LINE_W-1:0]         line,
  output logic [DATA_W-1:0]         rword
);
  logic [DATA_W-1:0] words [BURST];

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      line  <= '0;
    end else if (fill) begin
      valid <= 1'b1;
      line  <= fill_line;
    end
  end

  for (genvar w = 0; w < BURST; w++) begin : g_word
    for (genvar b = 0; b < BE_W; b++) begin : g_byte
      always_ff @(posedge clk) begin
        if (fill)
          words[w][b*8 +: 8] <= fill_data[w*DATA_W + b*8 +: 8];
        else if (upd && sel == OFF_W'(w) && be[b])
          words[w][b*8 +: 8] <= wdata[b*8 +: 8];
      end
    end
  end

  assign rword = words[sel];

  // R8: a patch only targets a line that is already valid
  p_upd_needs_valid_r8: assert property (@(posedge clk) disable iff (rst) upd |-> valid);
endmodule

// File: rtl/burst_cache_bridge.sv
module burst_cache_bridge
  import burst_bridge_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  localparam int BURST  = 4,
  localparam int OFF_W  = $clog2(BURST),
  localparam int LINE_W = ADDR_W - OFF_W,
  localparam int BE_W   = DATA_W / 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cpu_req,
  input  logic                      cpu_we,
  input  logic [ADDR_W-1:0]         cpu_addr,
  input  logic [DATA_W-1:0]         cpu_wdata,
  input  logic [BE_W-1:0]           cpu_be,
  output logic                      cpu_ack,
  output logic [DATA_W-1:0]         cpu_rdata,
  output logic                      mem_req,
  output logic                      mem_we,
  output logic [LINE_W-1:0]         mem_addr,
  output logic [BURST*DATA_W-1:0]   mem_wdata,
  output logic [BURST*BE_W-1:0]     mem_be,
  input  logic                      mem_ack,
  input  logic [BURST*DATA_W-1:0]   mem_rdata
);
  bridge_state_t state;

  logic              wb_pend, rl_valid;
  logic [LINE_W-1:0] wb_line, rl_line;
  logic [DATA_W-1:0] rl_word;

  wire [LINE_W-1:0] cpu_line = cpu_addr[ADDR_W-1:OFF_W];
  wire [OFF_W-1:0]  cpu_off  = cpu_addr[OFF_W-1:0];

  wire take       = (state == ST_IDLE) && cpu_req && !cpu_ack;
  wire wr_same    = wb_pend && (wb_line == cpu_line);
  wire rd_hit     = rl_valid && (rl_line == cpu_line);
  wire wr_accept  = take && cpu_we && (!wb_pend || wr_same);
  wire rd_accept  = take && !cpu_we && rd_hit;
  wire need_drain = take && wb_pend && (cpu_we ? !wr_same : !rd_hit);
  wire need_fill  = take && !cpu_we && !rd_hit && !wb_pend;

  burst_wbuf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BURST(BURST)) u_wbuf (
    .clk(clk), .rst(rst),
    .load(wr_accept && !wb_pend),
    .merge(wr_accept && wb_pend),
    .clear((state == ST_WDRAIN) && mem_ack),
    .line_in(cpu_line), .sel(cpu_off), .wdata(cpu_wdata), .be(cpu_be),
    .pend(wb_pend), .line(wb_line), .data_flat(mem_wdata), .be_flat(mem_be)
  );

  burst_rline #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BURST(BURST)) u_rline (
    .clk(clk), .rst(rst),
    .fill((state == ST_RFILL) && mem_ack),
    .fill_line(mem_addr), .fill_data(mem_rdata),
    .upd(wr_accept && rd_hit),
    .sel(cpu_off), .wdata(cpu_wdata), .be(cpu_be),
    .valid(rl_valid), .line(rl_line), .rword(rl_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cpu_ack   <= 1'b0;
      cpu_rdata <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
    end else begin
      cpu_ack <= wr_accept || rd_accept;
      if (rd_accept) cpu_rdata <= rl_word;
      unique case (state)
        ST_IDLE: begin
          if (need_drain) begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b1;
            mem_addr <= wb_line;
            state    <= ST_WDRAIN;
          end else if (need_fill) begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= cpu_line;
            state    <= ST_RFILL;
          end
        end
        ST_WDRAIN, ST_RFILL: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            state   <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9: request and its attributes hold until memory acknowledges
  p_req_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  // R4: a write burst always comes from a pending buffer with some byte enabled
  p_wr_mask_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (wb_pend && mem_be != '0));
  // R6: no read burst while a write is still pending
  p_rd_after_drain_r6: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we) |-> !wb_pend);
  // R2: acknowledge is a single-cycle pulse
  p_ack_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    cpu_ack |=> !cpu_ack);
endmodule

// File: tb/burst_cache_bridge_test.sv
`timescale 1ns/1ps
module burst_cache_bridge_test;
  localparam int AW = 8;
  localparam int NW = 1 << AW;

  logic clk = 1'b0, rst = 1'b1;
  logic cpu_req = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [15:0] cpu_wdata = '0;
  logic [1:0] cpu_be = '0;
  logic cpu_ack;
  logic [15:0] cpu_rdata;
  logic mem_req, mem_we;
  logic [AW-3:0] mem_addr;
  logic [63:0] mem_wdata, mem_rdata;
  logic [7:0] mem_be;
  logic mem_ack = 1'b0;

  burst_cache_bridge #(.ADDR_W(AW), .DATA_W(16)) uut (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_be(cpu_be), .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_be(mem_be), .mem_ack(mem_ack), .mem_rdata(mem_rdata));

  always #2.5 clk = ~clk;

  logic [15:0] mem [NW];
  logic [15:0] ref_mem [NW];
  int checks = 0, errors = 0, cyc_cnt = 0;
  bit timed_out = 1'b0;
  int wr_bursts = 0, rd_bursts = 0, lat = 2;
  bit last_we, prev_we;
  logic [AW-3:0] last_line, prev_line;
  logic [7:0] last_be;

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 150000) timed_out = 1'b1;
  end

  // memory model: answers after a short latency with a one-cycle ack
  always @(negedge clk) begin
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      if (lat == 0) begin
        prev_we = last_we; prev_line = last_line;
        last_we = mem_we; last_line = mem_addr;
        for (int w = 0; w < 4; w++) begin
          if (mem_we) begin
            if (mem_be[2*w])   mem[{mem_addr, 2'(w)}][7:0]  = mem_wdata[16*w +: 8];
            if (mem_be[2*w+1]) mem[{mem_addr, 2'(w)}][15:8] = mem_wdata[16*w+8 +: 8];
          end else mem_rdata[16*w +: 16] = mem[{mem_addr, 2'(w)}];
        end
        if (mem_we) begin wr_bursts++; last_be = mem_be; end
        else rd_bursts++;
        mem_ack = 1'b1;
        lat = 1 + ($urandom % 3);
      end else lat--;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cpu_op(input bit we, input logic [AW-1:0] a, input logic [15:0] d,
                        input logic [1:0] be, output logic [15:0] q, output int cyc);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d; cpu_be = be;
    cyc = 0;
    do begin @(negedge clk); cyc++; end while (!cpu_ack && !timed_out);
    q = cpu_rdata;
    cpu_req = 1'b0;
    if (we) begin
      if (be[0]) ref_mem[a][7:0]  = d[7:0];
      if (be[1]) ref_mem[a][15:8] = d[15:8];
    end
  endtask

  initial begin
    logic [15:0] q;
    int cyc, wb0, rb0;
    void'($urandom(32'd1234));
    mem_rdata = '0;
    for (int i = 0; i < NW; i++) begin
      mem[i] = 16'(i * 257) ^ 16'h5a3c;
      ref_mem[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cpu_ack == 1'b0 && mem_req == 1'b0, "R1 idle after reset", {cpu_ack, mem_req}, 0);

    cpu_op(1'b0, 8'h01, 0, 0, q, cyc);
    chk(q == ref_mem[8'h01], "R1 first read data", q, ref_mem[8'h01]);
    chk(rd_bursts == 1, "R1 first read misses", rd_bursts, 1);

    cpu_op(1'b0, 8'h03, 0, 0, q, cyc);
    chk(cyc == 1 && rd_bursts == 1, "R7 hit latency", cyc, 1);
    chk(q == ref_mem[8'h03], "R7 hit data", q, ref_mem[8'h03]);

    cpu_op(1'b1, 8'h10, 16'hA1B2, 2'b11, q, cyc);
    chk(cyc == 1 && wr_bursts == 0 && !mem_req, "R2 posted write", cyc, 1);
    cpu_op(1'b1, 8'h11, 16'hC3D4, 2'b01, q, cyc);
    chk(cyc == 1, "R3 merge ack", cyc, 1);
    cpu_op(1'b1, 8'h13, 16'hE5F6, 2'b10, q, cyc);
    chk(cyc == 1 && wr_bursts == 0, "R3 no burst on merge", wr_bursts, 0);

    cpu_op(1'b1, 8'h20, 16'h1234, 2'b11, q, cyc);
    chk(cyc > 1 && wr_bursts == 1, "R5 stall until drained", cyc, 2);
    chk(last_be == 8'h87, "R4 merged mask", last_be, 8'h87);
    chk(last_line == 6'h04, "R10 line index", last_line, 6'h04);
    chk(mem[8'h11] == ref_mem[8'h11] && mem[8'h13] == ref_mem[8'h13],
        "R4 untouched bytes", {mem[8'h11], mem[8'h13]}, {ref_mem[8'h11], ref_mem[8'h13]});

    wb0 = wr_bursts;
    cpu_op(1'b0, 8'h13, 0, 0, q, cyc);
    chk(q == ref_mem[8'h13], "R6 read after drain data", q, ref_mem[8'h13]);
    chk(wr_bursts == wb0 + 1 && prev_we && prev_line == 6'h08 && !last_we && last_line == 6'h04,
        "R6 drain before fetch", {prev_we, prev_line, last_we, last_line}, {1'b1, 6'h08, 1'b0, 6'h04});

    rb0 = rd_bursts;
    cpu_op(1'b1, 8'h12, 16'h7788, 2'b10, q, cyc);
    cpu_op(1'b0, 8'h12, 0, 0, q, cyc);
    chk(cyc == 1 && rd_bursts == rb0, "R8 hit after write", cyc, 1);
    chk(q == ref_mem[8'h12], "R8 patched data", q, ref_mem[8'h12]);

    for (int n = 0; n < 400 && !timed_out; n++) begin
      logic [AW-1:0] a;
      a = AW'($urandom % 48);
      if ($urandom % 2) cpu_op(1'b1, a, 16'($urandom), 2'(1 + $urandom % 3), q, cyc);
      else begin
        cpu_op(1'b0, a, 0, 0, q, cyc);
        chk(q == ref_mem[a], "R8 random read coherence", q, ref_mem[a]);
      end
    end

    if (timed_out) chk(1'b0, "watchdog", cyc_cnt, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule